// File: doc/BRIEF.md
# Synchronous Byte Serial Shifter

This block moves one byte at a time over a three-wire synchronous link: a shift clock, a serial data output and a serial data input. Transmit and receive happen together. A byte handed in on the transmit stream is shifted out on `sdo` while a byte is assembled from `sdi`. When the eighth bit has been taken in, the assembled byte appears on the receive stream. Software or a neighbouring block picks the bit order and the clock source. The bit order is either most significant bit first or least significant bit first. The clock source is either one of three internal rates divided from the system clock or a clock that arrives from the far end.

The transmit side is a valid/ready stream. A byte is accepted, and a transfer starts, in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low for the whole transfer, so a producer that holds `tx_valid` waits there. A request made while a transfer is running starts nothing. The receive side is also a valid/ready stream. `rx_valid` doubles as the completion flag and holds the byte until a cycle with `rx_ready` high, or until the next accepted transmit byte, whichever comes first. The received byte is not protected against overrun: the next accepted transfer takes it away.

When an internal rate is selected, the block drives the shift clock, which idles high. With the external source, the clock comes in on `sck_i`. It is brought into the system clock domain and its edges are detected there. In both cases `sdo` changes on the falling edge of the shift clock and `sdi` is sampled on the rising edge.

Top module: `sio_shifter`

## Requirements
- R1: After reset, `busy` and `rx_valid` are 0, `tx_ready`, `sck_o` and `sdo` are 1.
- R2: A cycle with `tx_valid` and `tx_ready` both high starts a transfer. `busy` is high from the next cycle on, and `tx_ready` equals the inverse of `busy`.
- R3: A transfer shifts exactly 8 bits. With an internal clock it keeps `busy` high for 16*H system cycles. H is 4, 16 or 64 for `cfg_clk_sel` = 2'b01, 2'b10 or 2'b11.
- R4: With `cfg_msb_first`=1, bit 7 of the transmit byte goes out first, and the first received bit ends up in `rx_data[7]`. With `cfg_msb_first`=0, bit 0 goes out first, and the first received bit ends up in `rx_data[0]`.
- R5: The internal shift clock periods are 8, 32 and 128 system cycles, with H cycles low and H cycles high. `sck_o` idles high, and `sck_oe` is 1 whenever `cfg_clk_sel` is not 2'b00.
- R6: `sdo` changes only on a falling shift-clock edge. `sdi` is sampled on a rising shift-clock edge.
- R7: With `cfg_clk_sel`=2'b00, the shift clock is taken from `sck_i` through a two-stage synchronizer, and `sck_oe` is 0.
- R8: On the rising edge that takes in the 8th bit, `busy` falls and `rx_valid` rises in the same cycle.
- R9: `rx_valid` clears after a cycle with `rx_ready` high. It also clears when a new transmit byte is accepted.
- R10: `tx_valid` asserted while `busy` is high is not accepted. The running transfer's output and its length are unchanged.
- R11: Bit order and clock source are captured when the transfer is accepted. Changing `cfg_*` during a transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_msb_first | input | 1 | 1: most significant bit first, 0: least significant bit first |
| cfg_clk_sel | input | 2 | 00 external, 01/10/11 internal period 8/32/128 cycles |
| tx_valid | input | 1 | Transmit byte offered / start request |
| tx_ready | output | 1 | High when idle; accepting starts a transfer |
| tx_data | input | 8 | Byte to transmit |
| rx_valid | output | 1 | Received byte available (completion flag) |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | Transfer in progress |
| sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Internal shift clock, idles high |
| sck_oe | output | 1 | Drive enable for `sck_o` |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The end of one transfer and the start of the next can fall next to each other. This happens when a producer holds `tx_valid` high through a whole transfer. On the edge where `busy` falls, the completed byte appears, and on the very next edge the waiting byte is accepted and clears `rx_valid`. The bench holds `tx_valid` across a transfer and samples in the single idle cycle between the two transfers. It checks that `rx_valid` is up in that cycle with the correct byte, and that one cycle later `busy` is high again and `rx_valid` is low. The same sweep also places a read handshake and a start request on either side of completion.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned SIO_BYTE_W = 8;

  typedef enum logic [1:0] {
    SCK_EXT   = 2'b00,
    SCK_FAST  = 2'b01,
    SCK_MID   = 2'b10,
    SCK_SLOW  = 2'b11
  } sck_src_e;
endpackage

// File: rtl/sio_rate_gen.sv
module sio_rate_gen
  import sio_pkg::*;
#(
  parameter int unsigned BASE_HALF = 4,
  parameter int unsigned STEP_LOG2 = 2,
  localparam int unsigned N_RATES  = 3,
  localparam int unsigned MAX_HALF = BASE_HALF << (STEP_LOG2 * (N_RATES - 1)),
  localparam int unsigned CW       = $clog2(MAX_HALF) + 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  sck_src_e src,
  output logic     sck,
  output logic     fall_p,
  output logic     rise_p
);
  logic [CW-1:0] lim [N_RATES];
  logic [CW-1:0] lim_cur;
  logic [CW-1:0] cnt;
  logic          active;
  logic          hit;

  // one terminal count per rate, each a factor 2^STEP_LOG2 apart
  for (genvar gi = 0; gi < N_RATES; gi++) begin : g_lim
    assign lim[gi] = CW'((BASE_HALF << (STEP_LOG2 * gi)) - 1);
  end

  always_comb begin
    case (src)
      SCK_FAST: lim_cur = lim[0];
      SCK_MID:  lim_cur = lim[1];
      SCK_SLOW: lim_cur = lim[2];
      default:  lim_cur = '0;
    endcase
  end

  assign active = run && (src != SCK_EXT);
  assign hit    = active && (cnt == lim_cur);
  assign fall_p = hit && sck;
  assign rise_p = hit && !sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (!active) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (hit) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sck) && $past(active)) |-> $past(cnt) == $past(lim_cur));
endmodule

// File: rtl/sio_ext_edge.sv
module sio_ext_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sck_in,
  output logic fall_p,
  output logic rise_p
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sck_in};
      prev_q <= cur;
    end
  end

  assign fall_p = en && prev_q && !cur;
  assign rise_p = en && !prev_q && cur;

  // R7
  ext_single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |=> !rise_p);
endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core
  import sio_pkg::*;
#(
  parameter int unsigned W  = SIO_BYTE_W,
  localparam int unsigned BW = $clog2(W) + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         msb_first,
  input  logic         fall_p,
  input  logic         rise_p,
  input  logic         sdi,
  input  logic         rd,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] sr,
  output logic         sdo
);
  logic          msb_q;
  logic [BW-1:0] bitcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      sr     <= '0;
      sdo    <= 1'b1;
      msb_q  <= 1'b1;
      bitcnt <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      sr     <= load_data;
      msb_q  <= msb_first;
      bitcnt <= '0;
    end else begin
      if (busy && fall_p) begin
        sdo <= msb_q ? sr[W-1] : sr[0];
      end
      if (busy && rise_p) begin
        sr     <= msb_q ? {sr[W-2:0], sdi} : {sdi, sr[W-1:1]};
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == BW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
      if (rd && done) begin
        done <= 1'b0;
      end
    end
  end

  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd && !busy) |=> !done);
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
#(
  parameter int unsigned W           = SIO_BYTE_W,
  parameter int unsigned BASE_HALF   = 4,
  parameter int unsigned STEP_LOG2   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_msb_first,
  input  logic [1:0]   cfg_clk_sel,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_data,
  output logic         rx_valid,
  input  logic         rx_ready,
  output logic [W-1:0] rx_data,
  output logic         busy,
  input  logic         sck_i,
  output logic         sck_o,
  output logic         sck_oe,
  output logic         sdo,
  input  logic         sdi
);
  sck_src_e src_q, eff_src;
  logic     load;
  logic     int_fall, int_rise, ext_fall, ext_rise;
  logic     fall_p, rise_p;
  logic     is_ext;

  assign tx_ready = !busy;
  assign load     = tx_valid && !busy;
  assign eff_src  = busy ? src_q : sck_src_e'(cfg_clk_sel);
  assign is_ext   = (eff_src == SCK_EXT);
  assign sck_oe   = !is_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    src_q <= SCK_FAST;
    else if (load) src_q <= sck_src_e'(cfg_clk_sel);
  end

  sio_rate_gen #(.BASE_HALF(BASE_HALF), .STEP_LOG2(STEP_LOG2)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(busy), .src(eff_src),
    .sck(sck_o), .fall_p(int_fall), .rise_p(int_rise)
  );

  sio_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst_n(rst_n), .en(busy && is_ext), .sck_in(sck_i),
    .fall_p(ext_fall), .rise_p(ext_rise)
  );

  assign fall_p = is_ext ? ext_fall : int_fall;
  assign rise_p = is_ext ? ext_rise : int_rise;

  sio_shift_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(tx_data),
    .msb_first(cfg_msb_first), .fall_p(fall_p), .rise_p(rise_p),
    .sdi(sdi), .rd(rx_ready), .busy(busy), .done(rx_valid),
    .sr(rx_data), .sdo(sdo)
  );

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_valid));
  // R5
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_o);
  // R8
  done_with_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_valid);
  // R6
  sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_ext && !$stable(sdo)) |-> $fell(sck_o));
endmodule

// File: tb/tb_sio_shifter.sv
module tb_sio_shifter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, cfg_msb_first, tx_valid, tx_ready, rx_valid, rx_ready;
  logic       busy, sck_i, sck_o, sck_oe, sdo, sdi;
  logic [1:0] cfg_clk_sel;
  logic [7:0] tx_data, rx_data;
  int n_run = 0, n_fail = 0;

  sio_shifter dut (
    .clk(clk), .rst_n(rst_n), .cfg_msb_first(cfg_msb_first), .cfg_clk_sel(cfg_clk_sel),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .busy(busy),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdo(sdo), .sdi(sdi)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xfer_int(input logic [1:0] sel, input bit msb, input logic [7:0] txb,
                          input logic [7:0] rxb, input bit disturb);
    int n = 0, fidx = 0, ridx = 0;
    bit prev = 1'b1;
    logic [7:0] got = '0;
    @(negedge clk);
    cfg_clk_sel = sel; cfg_msb_first = msb; tx_data = txb; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R2", "busy after accept", busy, 1);
    chk("R9", "rx_valid cleared by start", rx_valid, 0);
    chk("R5", "sck_oe internal", sck_oe, 1);
    forever begin
      if (prev && !sck_o && fidx < 8) begin
        sdi = msb ? rxb[7-fidx] : rxb[fidx];
        fidx++;
      end
      if (!prev && sck_o) begin
        got = msb ? {got[6:0], sdo} : {sdo, got[7:1]};
        ridx++;
      end
      prev = sck_o;
      if (!busy) break;
      n++;
      if (disturb && n == 10) begin
        tx_valid = 1'b1; tx_data = ~txb;
        chk("R10", "tx_ready while busy", tx_ready, 0);
      end
      if (disturb && n == 11) tx_valid = 1'b0;
      if (disturb && n == 20) begin
        cfg_msb_first = !msb; cfg_clk_sel = (sel == 2'd3) ? 2'd1 : 2'd3;
      end
      @(negedge clk);
    end
    chk(disturb ? "R11" : "R3", "busy length", n, 16 * (4 << (2 * (sel - 1))));
    chk("R3", "rising edges", ridx, 8);
    chk(disturb ? "R10" : "R4", "serial tx byte", got, txb);
    chk("R4", "rx_data", rx_data, rxb);
    chk("R8", "rx_valid at completion", rx_valid, 1);
    chk("R5", "sck idle high", sck_o, 1);
  endtask

  task automatic xfer_ext(input bit msb, input logic [7:0] txb, input logic [7:0] rxb);
    logic [7:0] got = '0;
    @(negedge clk);
    cfg_clk_sel = 2'd0; cfg_msb_first = msb; tx_data = txb; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R7", "sck_oe external", sck_oe, 0);
    for (int k = 0; k < 8; k++) begin
      sck_i = 1'b0;
      repeat (3) @(negedge clk);
      sdi = msb ? rxb[7-k] : rxb[k];
      repeat (7) @(negedge clk);
      got = msb ? {got[6:0], sdo} : {sdo, got[7:1]};
      sck_i = 1'b1;
      repeat (10) @(negedge clk);
    end
    chk("R7", "ext busy done", busy, 0);
    chk("R7", "ext serial tx byte", got, txb);
    chk("R4", "ext rx_data", rx_data, rxb);
    chk("R8", "ext rx_valid", rx_valid, 1);
  endtask

  task automatic do_read;
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    chk("R9", "rx_valid after read", rx_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_msb_first = 1'b1; cfg_clk_sel = 2'd1; tx_valid = 1'b0;
    tx_data = '0; rx_ready = 1'b0; sck_i = 1'b1; sdi = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "busy reset", busy, 0);
    chk("R1", "rx_valid reset", rx_valid, 0);
    chk("R1", "tx_ready reset", tx_ready, 1);
    chk("R1", "sck_o reset", sck_o, 1);
    chk("R1", "sdo reset", sdo, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep of rates, orders and bytes
    for (int sel = 1; sel < 4; sel++)
      for (int m = 0; m < 2; m++)
        for (int k = 0; k < 4; k++) begin
          logic [7:0] t;
          t = 8'h96 ^ 8'(k * 8'h35);
          xfer_int(2'(sel), m[0], t, ~{t[3:0], t[7:4]}, 1'b0);
          if (k == 3) do_read;
        end

    // busy-time requests and configuration changes
    xfer_int(2'd1, 1'b1, 8'hC4, 8'h2B, 1'b1);
    xfer_int(2'd2, 1'b0, 8'h1E, 8'hD0, 1'b1);
    do_read;

    // external clock
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 3; k++) begin
        logic [7:0] t;
        t = 8'h81 ^ 8'(k * 8'h4B);
        xfer_ext(m[0], t, {t[0], t[7:1]} ^ 8'h5A);
      end
    do_read;

    // completion meeting a held start request
    sdi = 1'b1;
    @(negedge clk);
    cfg_clk_sel = 2'd1; cfg_msb_first = 1'b1; tx_data = 8'h5A; tx_valid = 1'b1;
    @(negedge clk);
    tx_data = 8'hC3;
    while (busy) @(negedge clk);
    chk("R8", "window rx_valid", rx_valid, 1);
    chk("R4", "window rx_data", rx_data, 8'hFF);
    chk("R2", "window tx_ready", tx_ready, 1);
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R2", "back-to-back busy", busy, 1);
    chk("R9", "start clears rx_valid", rx_valid, 0);
    while (busy) @(negedge clk);
    chk("R8", "second completion", rx_valid, 1);
    do_read;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule